// File: doc/BRIEF.md
# Adaptive Incremental-Pulse Erase Sequencer

This block runs the erase of one flash block as a chain of erase loops. Each loop drives an erase pulse at the current voltage step for a set number of time-base ticks. It then asks an external sense path for a verify read, which answers with the number of cells that are still not erased. When that number falls below a programmable pass threshold, the erase ends with success. Otherwise the voltage step goes up by one and another loop is launched, unless the loop limit or the total tick budget forbids it, in which case the erase ends with a fail status.

Two pulse-time policies are available. Fixed mode repeats one preset pulse time in every loop. Adaptive mode uses the preset only for the first loop. For each later loop it compares the last fail-bit count against seven ascending breakpoints, and the number of breakpoints reached selects one of eight pulse times from a small table. Lightly worn blocks therefore receive short pulses. An under-predicted pulse is caught by the next verify and only costs one more loop. Firmware programs the block through a small register-write port while the sequencer is idle, starts an erase with a one-cycle strobe, and reads the result from held status outputs when `done` pulses.

Top module: `erase_loop_seq`

## Requirements
- R1: In each loop, `pulse_en` is high for exactly (pulse ticks × tick divisor) consecutive cycles. `vfy_req` rises only after `pulse_en` falls, stays high until `vfy_ack` is seen, and drops on the cycle after it.
- R2: A verify count strictly below the threshold (register address 0) ends the erase with `st_pass`=1 and no further pulse.
- R3: A verify count at or above the threshold, with the limits not reached, launches another loop at `vstep` one higher. `vstep` is 0 in the first loop, saturates at its all-ones value, and is constant during a pulse.
- R4: With mode (address 3, bit 0) at 0, every loop uses the fixed pulse ticks held at address 2.
- R5: With mode bit 0 at 1, the first loop uses the fixed ticks. A later loop uses table entry k (address 16+k), where k is the number of breakpoints (address 8+i, i = 0..6, ascending) that are less than or equal to the previous count.
- R6: When a verify fails and the loops used equal the loop limit (address 1), the erase ends with `st_pass`=0.
- R7: If the ticks already applied plus the next pulse's ticks would exceed the tick budget (address 5), the erase ends with `st_pass`=0 without issuing that pulse.
- R8: `done` is a one-cycle pulse at the end of an erase. At that point `st_pass`, `st_loops` (loops issued) and `st_ticks` (sum of applied pulse ticks) take their final values and hold them until the next erase ends.
- R9: `start` and register writes are ignored while `busy` is high.
- R10: After reset, `busy`, `done`, `pulse_en`, `vfy_req`, `vstep`, `st_pass`, `st_loops` and `st_ticks` are all 0.
- R11: A pulse-tick value of 0 is applied as 1 tick. A tick divisor (address 4, cycles per tick) of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle erase start strobe |
| busy | output | 1 | Erase in progress |
| done | output | 1 | One-cycle end-of-erase pulse |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wdata | input | DATA_W | Register write data |
| pulse_en | output | 1 | Erase pulse active |
| vstep | output | VS_W | Erase voltage step index |
| vfy_req | output | 1 | Verify-read request |
| vfy_ack | input | 1 | Verify result valid (one cycle) |
| vfy_fail_cnt | input | CNT_W | Fail-bit count of the verify |
| st_pass | output | 1 | Last erase succeeded |
| st_loops | output | LOOP_W | Loops issued by the last erase |
| st_ticks | output | TOT_W | Pulse ticks spent by the last erase |

## Verification
The properties assume that the sense path raises `vfy_ack` for exactly one cycle, and only while `vfy_req` is high. They also assume that `start` is a single-cycle strobe. The bench's responder meets this by answering a request on the first negative edge that sees it and clearing the acknowledge on the next one. The bench only ever programs breakpoints in ascending order, because the table index is defined as a count of breakpoints reached. Every sweep is replayed in both pulse policies with the same fail-count scripts, so the fixed and adaptive expectations come from identical stimulus.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_PULSE,
    ST_VREQ,
    ST_DECIDE
  } seq_state_t;

  // register address map
  localparam int A_THR      = 0;
  localparam int A_MAXL     = 1;
  localparam int A_FIXED    = 2;
  localparam int A_MODE     = 3;
  localparam int A_DIV      = 4;
  localparam int A_BUDGET   = 5;
  localparam int A_BP_BASE  = 8;
  localparam int A_TBL_BASE = 16;

endpackage

// File: rtl/erase_cfg_regs.sv
module erase_cfg_regs
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 16,
  parameter int PT_W        = 8,
  parameter int LOOP_W      = 4,
  parameter int DIV_W       = 16,
  parameter int TOT_W       = 12,
  parameter int N_BP        = 7,
  parameter int IDX_W       = 3,
  parameter int DEF_THR     = 16,
  parameter int DEF_MAXL    = 5,
  parameter int DEF_FIXED   = 7,
  parameter int DEF_DIV     = 50000,
  parameter int DEF_BUDGET  = 40,
  parameter int DEF_BP_STEP = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lock,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [CNT_W-1:0]        thr,
  output logic [LOOP_W-1:0]       max_loops,
  output logic [PT_W-1:0]         fixed_pt,
  output logic                    adaptive,
  output logic [DIV_W-1:0]        div,
  output logic [TOT_W-1:0]        budget,
  output logic [N_BP*CNT_W-1:0]   bp_flat,
  output logic [PT_W-1:0]         rd_data
);

  localparam int N_ENT = N_BP + 1;

  logic wr_ok;
  logic tbl_sel;
  logic [IDX_W-1:0] tbl_wi;
  logic [PT_W-1:0] tbl_mem [N_ENT];

  assign wr_ok   = we && !lock;
  assign tbl_sel = (int'(addr) >= A_TBL_BASE) && (int'(addr) < A_TBL_BASE + N_ENT);
  assign tbl_wi  = IDX_W'(int'(addr) - A_TBL_BASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      thr       <= CNT_W'(DEF_THR);
      max_loops <= LOOP_W'(DEF_MAXL);
      fixed_pt  <= PT_W'(DEF_FIXED);
      adaptive  <= 1'b0;
      div       <= DIV_W'(DEF_DIV);
      budget    <= TOT_W'(DEF_BUDGET);
    end else if (wr_ok) begin
      case (int'(addr))
        A_THR:    thr       <= wdata[CNT_W-1:0];
        A_MAXL:   max_loops <= wdata[LOOP_W-1:0];
        A_FIXED:  fixed_pt  <= wdata[PT_W-1:0];
        A_MODE:   adaptive  <= wdata[0];
        A_DIV:    div       <= wdata[DIV_W-1:0];
        A_BUDGET: budget    <= wdata[TOT_W-1:0];
        default:  ;
      endcase
    end
  end

  // breakpoint bank: all compared in parallel, so kept in flops
  for (genvar i = 0; i < N_BP; i++) begin : g_bp
    logic [CNT_W-1:0] bp_q;
    always_ff @(posedge clk) begin
      if (rst)
        bp_q <= CNT_W'((i + 1) * DEF_BP_STEP);
      else if (wr_ok && int'(addr) == A_BP_BASE + i)
        bp_q <= wdata[CNT_W-1:0];
    end
    assign bp_flat[i*CNT_W +: CNT_W] = bp_q;
  end

  // pulse table: plain write port and registered read, RAM friendly
  always_ff @(posedge clk) begin
    if (wr_ok && tbl_sel)
      tbl_mem[tbl_wi] <= wdata[PT_W-1:0];
  end

  always_ff @(posedge clk) begin
    rd_data <= tbl_mem[rd_idx];
  end

endmodule

// File: rtl/erase_bp_index.sv
module erase_bp_index #(
  parameter int CNT_W = 16,
  parameter int N_BP  = 7,
  parameter int IDX_W = 3
) (
  input  logic [CNT_W-1:0]      cnt,
  input  logic [N_BP*CNT_W-1:0] bp_flat,
  output logic [IDX_W-1:0]      idx
);

  logic [N_BP-1:0] reached;

  for (genvar i = 0; i < N_BP; i++) begin : g_cmp
    assign reached[i] = cnt >= bp_flat[i*CNT_W +: CNT_W];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N_BP; i++)
      idx = idx + IDX_W'(reached[i]);
  end

endmodule

// File: rtl/erase_tick_timer.sv
module erase_tick_timer #(
  parameter int DIV_W = 16,
  parameter int PT_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic [PT_W-1:0]  len,
  output logic             last
);

  logic [DIV_W-1:0] cyc_q;
  logic [PT_W-1:0]  tk_q;
  logic             tick;

  assign tick = ({1'b0, cyc_q} + (DIV_W+1)'(1)) >= {1'b0, div};
  assign last = run && tick && (({1'b0, tk_q} + (PT_W+1)'(1)) >= {1'b0, len});

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cyc_q <= '0;
      tk_q  <= '0;
    end else if (tick) begin
      cyc_q <= '0;
      tk_q  <= tk_q + PT_W'(1);
    end else begin
      cyc_q <= cyc_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/erase_loop_seq.sv
module erase_loop_seq
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 16,
  parameter int PT_W        = 8,
  parameter int LOOP_W      = 4,
  parameter int DIV_W       = 16,
  parameter int TOT_W       = 12,
  parameter int VS_W        = 4,
  parameter int N_BP        = 7,
  parameter int DEF_THR     = 16,
  parameter int DEF_MAXL    = 5,
  parameter int DEF_FIXED   = 7,
  parameter int DEF_DIV     = 50000,
  parameter int DEF_BUDGET  = 40,
  parameter int DEF_BP_STEP = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              pulse_en,
  output logic [VS_W-1:0]   vstep,
  output logic              vfy_req,
  input  logic              vfy_ack,
  input  logic [CNT_W-1:0]  vfy_fail_cnt,
  output logic              st_pass,
  output logic [LOOP_W-1:0] st_loops,
  output logic [TOT_W-1:0]  st_ticks
);

  localparam int N_ENT = N_BP + 1;
  localparam int IDX_W = $clog2(N_ENT);

  seq_state_t state_q;
  logic [LOOP_W-1:0] loops_q;
  logic [TOT_W-1:0]  total_q;
  logic [VS_W-1:0]   vstep_q;
  logic [PT_W-1:0]   pt_cur_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              first_q;

  logic [CNT_W-1:0]      thr;
  logic [LOOP_W-1:0]     max_loops;
  logic [PT_W-1:0]       fixed_pt;
  logic                  adaptive;
  logic [DIV_W-1:0]      div;
  logic [TOT_W-1:0]      budget;
  logic [N_BP*CNT_W-1:0] bp_flat;
  logic [PT_W-1:0]       tbl_q;
  logic [IDX_W-1:0]      tbl_idx;
  logic                  tmr_last;

  logic [PT_W-1:0] pt_pick;
  logic [PT_W-1:0] pt_eff;
  logic            over_budget;

  assign busy     = (state_q != ST_IDLE);
  assign pulse_en = (state_q == ST_PULSE);
  assign vfy_req  = (state_q == ST_VREQ);
  assign vstep    = vstep_q;

  erase_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PT_W(PT_W),
    .LOOP_W(LOOP_W), .DIV_W(DIV_W), .TOT_W(TOT_W), .N_BP(N_BP),
    .IDX_W(IDX_W), .DEF_THR(DEF_THR), .DEF_MAXL(DEF_MAXL),
    .DEF_FIXED(DEF_FIXED), .DEF_DIV(DEF_DIV), .DEF_BUDGET(DEF_BUDGET),
    .DEF_BP_STEP(DEF_BP_STEP)
  ) u_cfg (
    .clk(clk), .rst(rst), .lock(busy), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rd_idx(tbl_idx), .thr(thr), .max_loops(max_loops),
    .fixed_pt(fixed_pt), .adaptive(adaptive), .div(div), .budget(budget),
    .bp_flat(bp_flat), .rd_data(tbl_q)
  );

  erase_bp_index #(
    .CNT_W(CNT_W), .N_BP(N_BP), .IDX_W(IDX_W)
  ) u_idx (
    .cnt(cnt_q), .bp_flat(bp_flat), .idx(tbl_idx)
  );

  erase_tick_timer #(
    .DIV_W(DIV_W), .PT_W(PT_W)
  ) u_tmr (
    .clk(clk), .rst(rst), .run(pulse_en), .div(div), .len(pt_cur_q),
    .last(tmr_last)
  );

  // the table read issued in DECIDE is valid here in LAUNCH
  assign pt_pick     = (first_q || !adaptive) ? fixed_pt : tbl_q;
  assign pt_eff      = (pt_pick == '0) ? PT_W'(1) : pt_pick;
  assign over_budget = ({1'b0, total_q} + (TOT_W+1)'(pt_eff)) > {1'b0, budget};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      loops_q  <= '0;
      total_q  <= '0;
      vstep_q  <= '0;
      pt_cur_q <= '0;
      cnt_q    <= '0;
      first_q  <= 1'b1;
      done     <= 1'b0;
      st_pass  <= 1'b0;
      st_loops <= '0;
      st_ticks <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            loops_q <= '0;
            total_q <= '0;
            vstep_q <= '0;
            first_q <= 1'b1;
            state_q <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: begin
          if (over_budget) begin
            state_q  <= ST_IDLE;
            done     <= 1'b1;
            st_pass  <= 1'b0;
            st_loops <= loops_q;
            st_ticks <= total_q;
          end else begin
            pt_cur_q <= pt_eff;
            total_q  <= total_q + TOT_W'(pt_eff);
            loops_q  <= loops_q + LOOP_W'(1);
            state_q  <= ST_PULSE;
          end
        end
        ST_PULSE: begin
          if (tmr_last) state_q <= ST_VREQ;
        end
        ST_VREQ: begin
          if (vfy_ack) begin
            cnt_q   <= vfy_fail_cnt;
            state_q <= ST_DECIDE;
          end
        end
        ST_DECIDE: begin
          if (cnt_q < thr) begin
            state_q  <= ST_IDLE;
            done     <= 1'b1;
            st_pass  <= 1'b1;
            st_loops <= loops_q;
            st_ticks <= total_q;
          end else if (loops_q >= max_loops) begin
            state_q  <= ST_IDLE;
            done     <= 1'b1;
            st_pass  <= 1'b0;
            st_loops <= loops_q;
            st_ticks <= total_q;
          end else begin
            if (vstep_q != {VS_W{1'b1}}) vstep_q <= vstep_q + VS_W'(1);
            first_q <= 1'b0;
            state_q <= ST_LAUNCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/erase_loop_seq_chk.sv
module erase_loop_seq_chk #(
  parameter int VS_W   = 4,
  parameter int LOOP_W = 4,
  parameter int TOT_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              pulse_en,
  input logic              vfy_req,
  input logic              vfy_ack,
  input logic [VS_W-1:0]   vstep,
  input logic [LOOP_W-1:0] st_loops,
  input logic [TOT_W-1:0]  st_ticks
);

  p_vreq_after_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(vfy_req) |-> $past(pulse_en));

  p_req_held_r1: assert property (@(posedge clk) disable iff (rst)
    vfy_req && !vfy_ack |=> vfy_req);

  p_req_drop_r1: assert property (@(posedge clk) disable iff (rst)
    vfy_req && vfy_ack |=> !vfy_req);

  p_vstep_hold_r3: assert property (@(posedge clk) disable iff (rst)
    pulse_en && $past(pulse_en) |-> $stable(vstep));

  p_vstep_mono_r3: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> vstep >= $past(vstep));

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !pulse_en);

  p_status_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !busy && !$past(busy) |-> $stable(st_loops) && $stable(st_ticks));

endmodule

bind erase_loop_seq erase_loop_seq_chk #(
  .VS_W(VS_W), .LOOP_W(LOOP_W), .TOT_W(TOT_W)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .pulse_en(pulse_en),
  .vfy_req(vfy_req), .vfy_ack(vfy_ack), .vstep(vstep),
  .st_loops(st_loops), .st_ticks(st_ticks)
);

// File: tb/erase_loop_seq_tb.sv
module erase_loop_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int VSW  = 3;
  localparam int VMAX = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        busy, done, pulse_en, vfy_req, st_pass;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [VSW-1:0] vstep;
  logic        vfy_ack = 1'b0;
  logic [15:0] vfy_fail_cnt = '0;
  logic [3:0]  st_loops;
  logic [11:0] st_ticks;

  always #(CLK_PERIOD/2) clk = ~clk;

  erase_loop_seq #(.VS_W(VSW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pulse_en(pulse_en), .vstep(vstep), .vfy_req(vfy_req),
    .vfy_ack(vfy_ack), .vfy_fail_cnt(vfy_fail_cnt), .st_pass(st_pass),
    .st_loops(st_loops), .st_ticks(st_ticks)
  );

  int n_chk = 0;
  int n_fail = 0;

  // model copy of the programmed registers
  int thr_m, maxl_m, fixed_m, div_m, budget_m;
  bit adapt_m;
  int bp_m [7];
  int tbl_m [8];

  // per-run stimulus and observations
  int scr [16];
  int mw [32];
  int mv [32];
  int np;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_reg(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 0) thr_m = d;
    else if (a == 1) maxl_m = d;
    else if (a == 2) fixed_m = d;
    else if (a == 3) adapt_m = d[0];
    else if (a == 4) div_m = d;
    else if (a == 5) budget_m = d;
    else if (a >= 8 && a < 15) bp_m[a-8] = d;
    else if (a >= 16 && a < 24) tbl_m[a-16] = d;
  endtask

  function automatic int lut_idx(int c);
    int k = 0;
    for (int i = 0; i < 7; i++) if (c >= bp_m[i]) k++;
    return k;
  endfunction

  task automatic run_erase(bit inject);
    int k = 0;
    int plen = 0;
    bit injected = 1'b0;
    bit finished = 1'b0;
    np = 0;
    @(negedge clk);
    start = 1'b1;
    for (int g = 0; g < 5000 && !finished; g++) begin
      @(negedge clk);
      start = 1'b0;
      cfg_we = 1'b0;
      if (vfy_ack) vfy_ack = 1'b0;
      else if (vfy_req) begin
        vfy_ack = 1'b1;
        vfy_fail_cnt = 16'(scr[k]);
        k++;
      end
      if (pulse_en) begin
        if (plen == 0) mv[np] = int'(vstep);
        plen++;
        if (inject && !injected && plen == 2) begin
          start = 1'b1;
          cfg_we = 1'b1; cfg_addr = 5'd2; cfg_wdata = 16'd9;
          injected = 1'b1;
        end
      end else if (plen > 0) begin
        mw[np] = plen;
        np++;
        plen = 0;
      end
      if (done) finished = 1'b1;
    end
    if (!finished) chk("R8", "done never seen", 0, 1);
  endtask

  // walks the loop sequence implied by the requirements
  task automatic check_model(string tag);
    int loops = 0;
    int total = 0;
    int step = 0;
    int pt = fixed_m;
    int pass = 0;
    int pe, c;
    int dv = (div_m == 0) ? 1 : div_m;
    while (1) begin
      pe = (pt == 0) ? 1 : pt;
      if (total + pe > budget_m) break;
      if (loops < np) begin
        chk("R1", {tag, " pulse width"}, mw[loops], pe * dv);
        chk("R3", {tag, " vstep"}, mv[loops], step);
      end
      loops++;
      total += pe;
      c = scr[loops-1];
      if (c < thr_m) begin pass = 1; break; end
      if (loops >= maxl_m) break;
      step = (step < VMAX) ? step + 1 : VMAX;
      pt = adapt_m ? tbl_m[lut_idx(c)] : fixed_m;
    end
    chk("R1", {tag, " pulse count"}, np, loops);
    chk("R2", {tag, " pass"}, int'(st_pass), pass);
    chk("R8", {tag, " loops"}, int'(st_loops), loops);
    chk("R8", {tag, " ticks"}, int'(st_ticks), total);
  endtask

  task automatic sweep(bit adapt);
    int cs [16];
    int n = 0;
    cs[n++] = 5; cs[n++] = 9;
    for (int j = 1; j < 8; j++) begin
      cs[n++] = 10 * j;
      cs[n++] = (j < 7) ? 10 * (j + 1) - 1 : 65535;
    end
    for (int i = 0; i < n; i++) begin
      scr[0] = cs[i]; scr[1] = 0;
      run_erase(1'b0);
      check_model(adapt ? "adaptive sweep" : "fixed sweep");
      if (adapt) chk("R5", "second pulse from table", mw[1], tbl_m[lut_idx(cs[i])] * div_m);
      else       chk("R4", "second pulse fixed", mw[1], fixed_m * div_m);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "busy", int'(busy), 0);
    chk("R10", "done", int'(done), 0);
    chk("R10", "pulse_en", int'(pulse_en), 0);
    chk("R10", "vfy_req", int'(vfy_req), 0);
    chk("R10", "vstep", int'(vstep), 0);
    chk("R10", "st_pass", int'(st_pass), 0);
    chk("R10", "st_loops", int'(st_loops), 0);
    chk("R10", "st_ticks", int'(st_ticks), 0);

    set_reg(0, 5); set_reg(1, 5); set_reg(2, 4); set_reg(3, 0);
    set_reg(4, 3); set_reg(5, 40);
    for (int i = 0; i < 7; i++) set_reg(8 + i, 10 * (i + 1));
    for (int j = 0; j < 8; j++) set_reg(16 + j, j + 1);

    // threshold edges
    scr[0] = 3; run_erase(1'b0); check_model("R2 clear pass");
    scr[0] = 4; run_erase(1'b0); check_model("R2 thr-1");
    scr[0] = 5; scr[1] = 0; run_erase(1'b0); check_model("R3 at thr");
    chk("R3", "second vstep", mv[1], 1);

    sweep(1'b0);
    set_reg(3, 1);
    sweep(1'b1);

    // loop limit
    for (int i = 0; i < 16; i++) scr[i] = 100;
    run_erase(1'b0); check_model("limit");
    chk("R6", "limit fail", int'(st_pass), 0);
    chk("R6", "limit loops", int'(st_loops), 5);

    // budget
    set_reg(5, 15);
    run_erase(1'b0); check_model("budget");
    chk("R7", "budget loops", int'(st_loops), 2);
    chk("R7", "budget ticks", int'(st_ticks), 12);
    set_reg(5, 40);

    // voltage step saturation
    set_reg(3, 0); set_reg(2, 1); set_reg(1, 10);
    run_erase(1'b0); check_model("saturation");
    chk("R3", "vstep saturated", mv[9], VMAX);

    // zero pulse ticks and zero divisor
    set_reg(2, 0); set_reg(4, 0);
    scr[0] = 0; run_erase(1'b0); check_model("zero");
    chk("R11", "zero pulse width", mw[0], 1);
    chk("R11", "zero ticks", int'(st_ticks), 1);

    // start and write while busy
    set_reg(2, 4); set_reg(4, 3); set_reg(1, 5);
    scr[0] = 50; scr[1] = 50; scr[2] = 0;
    run_erase(1'b1); check_model("busy inject");
    chk("R9", "no restart loops", int'(st_loops), 3);
    chk("R9", "write ignored pulse", mw[2], 12);
    scr[0] = 0; run_erase(1'b0);
    chk("R9", "fixed reg unchanged", mw[0], 12);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule